// File: doc/BRIEF.md
# PS/2 Peripheral-Side Link Controller

This block sits at the peripheral end of a two-wire PS/2 connection. It drives the bus clock for every transfer, whichever side is sending data. It frames bytes handed to it from the parallel side and shifts them out. It also accepts bytes that the host starts with a request-to-send. Each host byte that arrives intact is answered automatically with the acknowledge byte 0xFA.

Both wires are open-drain. An output-enable pulls a wire low, and the matching input reads the level on the wire. A logic 1 is sent by releasing the wire. The host can hold the clock low to inhibit the block. While inhibited, the block starts nothing. If the inhibit arrives in the middle of a byte, the block abandons the frame and sends the whole byte again once the bus has gone idle.

Bit timing comes from the parameter `HALF`, which is the number of system clock cycles in each half of a bus clock period. At 50 MHz the default of 2000 gives an 80 µs period.

Top module: `ps2_dev_link`

## Requirements
- R1: After reset both enables are low (both wires released), `tx_ready` is 1 and `rx_valid` is 0.
- R2: Every frame, in either direction, carries exactly 11 low clock pulses. Each low phase and each high phase lasts `HALF` system cycles. A received frame has one extra pulse, described in R7.
- R3: The data enable changes only while the clock enable is low (bus clock high). It stays constant through every low pulse.
- R4: An outgoing frame is sent in this order: a 0 start bit, eight data bits LSB first, a parity bit that makes the nine bits odd in ones, and a 1 stop bit.
- R5: While the host holds the clock wire low, no frame starts and both wires stay released.
- R6: If the host holds the clock low during an outgoing frame, both wires are released within `HALF`+4 cycles. The full byte is sent again from its start bit once the clock and data wires are both high.
- R7: A host request-to-send is the clock wire high while the data wire is low. The block answers it by clocking in 11 bits, then holding data low through a 12th clock pulse. If the start bit is 0, the stop bit is 1 and parity is odd, the byte appears on `rx_byte` with a single-cycle `rx_valid` pulse.
- R8: A received frame with bad parity or a bad stop bit produces no `rx_valid` pulse and no answering frame.
- R9: Each accepted host byte is followed by an outgoing frame carrying 0xFA.
- R10: A pending 0xFA is sent before a parallel-side byte that was already waiting.
- R11: The parallel side holds one byte. `tx_ready` drops in the cycle after a byte is accepted and stays low until that byte's frame has completed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ps2_clk_in | input | 1 | Level read from the bus clock wire |
| ps2_clk_oe | output | 1 | 1 pulls the bus clock wire low |
| ps2_dat_in | input | 1 | Level read from the bus data wire |
| ps2_dat_oe | output | 1 | 1 pulls the bus data wire low |
| tx_byte | input | 8 | Byte to send to the host |
| tx_valid | input | 1 | `tx_byte` is offered |
| tx_ready | output | 1 | A byte can be accepted |
| rx_byte | output | 8 | Last accepted host byte |
| rx_valid | output | 1 | One-cycle strobe for `rx_byte` |

## Verification
The bench builds the block with `HALF` set to 8. This makes a frame about 180 cycles long, so many frames fit in one run: a table of outgoing bytes, good and bad host bytes, the acknowledge-before-data ordering, and inhibits that fall both before a frame and in the middle of one. The small value still leaves room for the two-stage input synchronisers inside each half period. A host model that changes data only while the clock is high can therefore exercise the sample point for real.

// File: rtl/ps2_dev_link.sv
module ps2_dev_link #(
  parameter int HALF = 2000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ps2_clk_in,
  output logic       ps2_clk_oe,
  input  logic       ps2_dat_in,
  output logic       ps2_dat_oe,
  input  logic [7:0] tx_byte,
  input  logic       tx_valid,
  output logic       tx_ready,
  output logic [7:0] rx_byte,
  output logic       rx_valid
);
  localparam int CW = $clog2(HALF + 1);

  typedef enum logic [1:0] {S_IDLE, S_TX, S_RX, S_GAP} st_t;

  st_t         st;
  logic [CW-1:0] cnt;
  logic        ph;
  logic [3:0]  idx;
  logic [10:0] sh, rsh;
  logic [1:0]  cs, ds;
  logic        send_ack, ack_pend, hold_v;
  logic [7:0]  hold;

  wire clk_s = cs[1];
  wire dat_s = ds[1];
  wire tick  = (cnt == CW'(HALF - 1));
  wire good  = !rsh[0] && rsh[10] && (^rsh[9:1]);

  function automatic logic [10:0] frame(input logic [7:0] b);
    return {1'b1, ~^b, b, 1'b0};
  endfunction

  assign tx_ready   = !hold_v;
  assign ps2_clk_oe = (st == S_TX || st == S_RX) && ph;
  assign ps2_dat_oe = (st == S_TX && !sh[0]) || (st == S_RX && idx == 4'd11);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs <= 2'b11;
      ds <= 2'b11;
    end else begin
      cs <= {cs[0], ps2_clk_in};
      ds <= {ds[0], ps2_dat_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      cnt      <= '0;
      ph       <= 1'b0;
      idx      <= '0;
      sh       <= '1;
      rsh      <= '0;
      send_ack <= 1'b0;
      ack_pend <= 1'b0;
      hold_v   <= 1'b0;
      hold     <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (tx_valid && !hold_v) begin
        hold   <= tx_byte;
        hold_v <= 1'b1;
      end
      case (st)
        S_IDLE: begin
          cnt <= '0;
          ph  <= 1'b0;
          idx <= '0;
          if (clk_s && !dat_s) begin
            st <= S_RX;
          end else if (clk_s && dat_s && (ack_pend || hold_v)) begin
            st       <= S_TX;
            send_ack <= ack_pend;
            sh       <= frame(ack_pend ? 8'hFA : hold);
          end
        end
        S_TX, S_RX: begin
          cnt <= tick ? '0 : cnt + 1'b1;
          if (tick) begin
            if (!ph) begin
              if (st == S_TX && !clk_s) begin
                st <= S_GAP;
              end else begin
                ph <= 1'b1;
                if (st == S_RX && idx != 4'd11) rsh <= {dat_s, rsh[10:1]};
              end
            end else begin
              ph  <= 1'b0;
              idx <= idx + 1'b1;
              if (st == S_TX) begin
                sh <= {1'b1, sh[10:1]};
                if (idx == 4'd10) begin
                  st <= S_GAP;
                  if (send_ack) ack_pend <= 1'b0;
                  else          hold_v   <= 1'b0;
                end
              end else if (idx == 4'd11) begin
                st <= S_GAP;
                if (good) begin
                  rx_valid <= 1'b1;
                  rx_byte  <= rsh[8:1];
                  ack_pend <= 1'b1;
                end
              end
            end
          end
        end
        default: begin
          cnt <= tick ? '0 : cnt + 1'b1;
          if (tick) begin
            ph <= ~ph;
            if (ph) st <= S_IDLE;
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/ps2_dev_link_chk.sv
module ps2_dev_link_chk #(
  parameter int HALF = 2000
) (
  input logic clk,
  input logic rst_n,
  input logic ps2_clk_in,
  input logic ps2_clk_oe,
  input logic ps2_dat_oe,
  input logic tx_valid,
  input logic tx_ready,
  input logic rx_valid
);
  logic [15:0] lowcnt, inh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lowcnt <= '0;
      inh    <= '0;
    end else begin
      lowcnt <= ps2_clk_oe ? lowcnt + 1'b1 : '0;
      if (!ps2_clk_in && !ps2_clk_oe) begin
        if (inh != 16'hFFFF) inh <= inh + 1'b1;
      end else begin
        inh <= '0;
      end
    end
  end

  assert_pulse_width_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ps2_clk_oe) |-> lowcnt == 16'(HALF));

  assert_data_steady_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ps2_clk_oe && $past(ps2_clk_oe) |-> $stable(ps2_dat_oe));

  assert_inhibit_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    inh > 16'(HALF + 4) |-> !ps2_dat_oe && !ps2_clk_oe);

  assert_rx_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  assert_hold_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid && tx_ready |=> !tx_ready);
endmodule

bind ps2_dev_link ps2_dev_link_chk #(.HALF(HALF)) chk_i (
  .clk(clk), .rst_n(rst_n), .ps2_clk_in(ps2_clk_in), .ps2_clk_oe(ps2_clk_oe),
  .ps2_dat_oe(ps2_dat_oe), .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_valid(rx_valid)
);

// File: tb/ps2_dev_link_tb_top.sv
module ps2_dev_link_tb_top;
  localparam int HALF = 8;
  localparam int NV = 6;
  localparam logic [7:0] VEC [NV] = '{8'h00, 8'hFF, 8'hA5, 8'h01, 8'h80, 8'h7E};

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_clk_low = 1'b0, host_dat_low = 1'b0;
  logic [7:0] tx_byte = '0;
  logic tx_valid = 1'b0;
  logic ps2_clk_oe, ps2_dat_oe, tx_ready, rx_valid;
  logic [7:0] rx_byte;
  wire ps2_clk_in = ~(ps2_clk_oe | host_clk_low);
  wire ps2_dat_in = ~(ps2_dat_oe | host_dat_low);

  int total = 0, bad = 0, wd = 0, pulses = 0, rx_cnt = 0;
  logic [7:0] rx_last = '0;
  logic steady_ok = 1'b1;

  always #10 clk = ~clk;

  ps2_dev_link #(.HALF(HALF)) dut_i (
    .clk(clk), .rst_n(rst_n), .ps2_clk_in(ps2_clk_in), .ps2_clk_oe(ps2_clk_oe),
    .ps2_dat_in(ps2_dat_in), .ps2_dat_oe(ps2_dat_oe), .tx_byte(tx_byte),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .rx_byte(rx_byte), .rx_valid(rx_valid)
  );

  always @(posedge ps2_clk_oe) pulses++;
  always @(negedge clk) if (rx_valid) begin rx_cnt++; rx_last = rx_byte; end

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    tx_byte = b; tx_valid = 1'b1;
    while (!tx_ready) @(negedge clk);
    @(negedge clk);
    tx_valid = 1'b0;
  endtask

  task automatic host_recv(output logic [10:0] f);
    for (int k = 0; k < 11; k++) begin
      logic a;
      @(posedge ps2_clk_oe); #1;
      a = ps2_dat_oe;
      f[k] = ~a;
      repeat (HALF - 2) @(negedge clk);
      if (ps2_dat_oe !== a) steady_ok = 1'b0;
    end
  endtask

  task automatic host_send(input logic [7:0] b, input logic badpar, output logic lack);
    logic [9:0] v;
    v = {1'b1, badpar ? ^b : ~^b, b};
    host_clk_low = 1'b1;
    repeat (30) @(negedge clk);
    host_dat_low = 1'b1;
    repeat (4) @(negedge clk);
    host_clk_low = 1'b0;
    for (int k = 0; k < 10; k++) begin
      @(posedge ps2_clk_oe);
      @(negedge ps2_clk_oe);
      host_dat_low = ~v[k];
    end
    @(posedge ps2_clk_oe);
    @(posedge ps2_clk_oe); #1;
    lack = ps2_dat_oe;
  endtask

  function automatic logic [10:0] fr(input logic [7:0] b);
    return {1'b1, ~^b, b, 1'b0};
  endfunction

  initial begin
    logic [10:0] f, f2;
    logic lack;
    int p0, r0;
    repeat (3) @(negedge clk);
    chk("R1 clk_oe", ps2_clk_oe, 0);
    chk("R1 dat_oe", ps2_dat_oe, 0);
    chk("R1 rx_valid", rx_valid, 0);
    chk("R1 tx_ready", tx_ready, 1);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 idle released", {ps2_clk_oe, ps2_dat_oe}, 0);

    for (int i = 0; i < NV; i++) begin
      p0 = pulses;
      send_byte(VEC[i]);
      chk("R11 ready low while held", tx_ready, 0);
      host_recv(f);
      chk("R4 frame bits", f, fr(VEC[i]));
      repeat (40) @(negedge clk);
      chk("R2 pulse count", pulses - p0, 11);
      chk("R11 ready after frame", tx_ready, 1);
    end
    chk("R3 data steady in low pulses", steady_ok, 1);

    r0 = rx_cnt;
    host_send(8'hF4, 1'b0, lack);
    chk("R7 line ack", lack, 1);
    host_recv(f);
    chk("R7 rx count", rx_cnt - r0, 1);
    chk("R7 rx byte", rx_last, 8'hF4);
    chk("R9 ack frame", f, fr(8'hFA));
    repeat (40) @(negedge clk);

    r0 = rx_cnt;
    host_send(8'h33, 1'b1, lack);
    chk("R7 line ack on bad frame", lack, 1);
    p0 = pulses;
    repeat (300) @(negedge clk);
    chk("R8 no answer frame", pulses - p0, 0);
    chk("R8 no rx strobe", rx_cnt - r0, 0);

    host_clk_low = 1'b1;
    send_byte(8'h55);
    host_send(8'h12, 1'b0, lack);
    host_recv(f);
    host_recv(f2);
    chk("R10 ack first", f, fr(8'hFA));
    chk("R10 data second", f2, fr(8'h55));
    chk("R9 rx byte 12", rx_last, 8'h12);
    repeat (40) @(negedge clk);

    host_clk_low = 1'b1;
    p0 = pulses;
    send_byte(8'h9C);
    repeat (200) @(negedge clk);
    chk("R5 no pulses while inhibited", pulses - p0, 0);
    chk("R5 lines released", {ps2_clk_oe, ps2_dat_oe}, 0);
    host_clk_low = 1'b0;
    host_recv(f);
    chk("R5 frame after release", f, fr(8'h9C));
    repeat (40) @(negedge clk);

    send_byte(8'h3C);
    repeat (3) @(posedge ps2_clk_oe);
    @(negedge ps2_clk_oe);
    host_clk_low = 1'b1;
    repeat (100) @(negedge clk);
    chk("R6 released on abort", {ps2_clk_oe, ps2_dat_oe}, 0);
    host_clk_low = 1'b0;
    host_recv(f);
    chk("R6 whole byte resent", f, fr(8'h3C));
    repeat (40) @(negedge clk);
    chk("R11 ready after retry", tx_ready, 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule